// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one read or write command into the ordered list of column addresses that a double-data-rate memory burst touches. Software or a controller first loads a 15-bit mode code. From that code the block takes the burst length (2, 4 or 8 beats), the beat ordering (linear with wrap, or XOR-interleaved) and the CAS latency code. Mode codes that use any reserved value are refused: an error pulse is raised and the stored mode does not change. Reset leaves a 2-beat linear mode with CAS latency code 010.

A command enters through a valid/ready handshake that carries the starting column. The block takes a command only while it is idle, so `cmd_ready` is low for the whole burst. An offer made during that time is held off by the handshake and has no effect. The address stream leaves as a plain `col_valid` qualifier with no back-pressure, because memory beats cannot be stalled: one address comes out on each cycle of the burst. Each address stays inside the aligned group of columns that the burst length selects, and wraps inside that group rather than carrying into the upper bits. Reads and writes share the same programmed length and ordering.

Top module: `burst_col_seq`

## Requirements
- R1: The burst length field is mode bits [2:0]. 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. Every other value is reserved.
- R2: Mode bit 3 picks the ordering: 0 is linear (sequential) and 1 is interleaved. Both orderings are legal with every legal length.
- R3: The CAS field is mode bits [6:4]. Only 010 and 110 are legal. `cas_code` always shows the stored CAS field.
- R4: A mode code is legal only when bits [14:13] are 00 and bits [12:7] are 000000 or 000010.
- R5: A load with any reserved field sets `mode_err` high for exactly the cycle after the load and leaves the stored mode unchanged. A legal load gives no error and takes effect from the next cycle.
- R6: After reset the stored mode is 2 beats, linear, CAS 010. `col_valid`, `busy` and `mode_err` are low and `cmd_ready` is high.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a burst runs, and an offer made during that time has no effect on the running burst or on later outputs.
- R8: The first beat appears on the cycle after acceptance and equals `cmd_col`. `col_valid` and `busy` are then high for exactly L consecutive cycles, where L is the burst length.
- R9: In linear order, the low log2(L) bits on beat i equal (start + i) mod L.
- R10: In interleaved order, the low log2(L) bits on beat i equal start XOR i.
- R11: The column bits at and above bit log2(L) equal those of the start column on every beat, so the burst wraps inside its aligned block.
- R12: A burst uses the mode stored when it is accepted. A load made in the same cycle as the command, or during the burst, affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Strobe to load `mode_code` |
| mode_code | input | 15 | Mode code to load |
| mode_err | output | 1 | One-cycle pulse after a refused (reserved) load |
| cas_code | output | 3 | Stored CAS latency field |
| cmd_valid | input | 1 | Command offer |
| cmd_ready | output | 1 | Block is idle and can accept a command |
| cmd_col | input | COL_W | Starting column of the command |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| col_addr | output | COL_W | Column address of the current beat |
| busy | output | 1 | A burst is running |

## Verification
The bound checker tests several properties on every cycle. The first beat must equal the accepted start column. Upper column bits must stay steady inside a run. Every run of `col_valid` must last 2, 4 or 8 beats. A refused load must not move the CAS code, and the CAS code must always be a legal value. Whether each beat has the exact low bits for its ordering and start, and whether the length matches the mode actually in force, can only be shown by the bench. So can the rejection of each class of reserved code, the blocking of offers made during a burst, and the rule that loads made alongside or during a burst take effect only for later bursts. The bench checks these against its own reference model over random and directed starts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Widest burst is 8 beats, so the in-block offset is 3 bits.
  localparam int unsigned OFS_W   = 3;
  localparam int unsigned MODE_W  = 15;
  localparam int unsigned CAS_W   = 3;

  typedef enum logic [1:0] {
    BLEN_2 = 2'd0,
    BLEN_4 = 2'd1,
    BLEN_8 = 2'd2
  } blen_e;

  typedef struct packed {
    blen_e            blen;
    logic             ilv;
    logic [CAS_W-1:0] cas;
  } mode_t;

  localparam mode_t MODE_RESET = '{blen: BLEN_2, ilv: 1'b0, cas: 3'b010};

  // Offset mask for the aligned block of a given length.
  function automatic logic [OFS_W-1:0] blen_mask(input blen_e b);
    case (b)
      BLEN_2:  blen_mask = 3'b001;
      BLEN_4:  blen_mask = 3'b011;
      default: blen_mask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] code,
  output mode_t             cur,
  output logic              err
);

  logic  bl_ok, cas_ok, op_ok, sel_ok, all_ok;
  blen_e bl_dec;

  // Length field decode
  always_comb begin
    bl_ok  = 1'b1;
    bl_dec = BLEN_2;
    case (code[2:0])
      3'b001:  bl_dec = BLEN_2;
      3'b010:  bl_dec = BLEN_4;
      3'b011:  bl_dec = BLEN_8;
      default: bl_ok  = 1'b0;
    endcase
  end

  assign cas_ok = (code[6:4] == 3'b010) || (code[6:4] == 3'b110);
  assign op_ok  = (code[12:7] == 6'b000000) || (code[12:7] == 6'b000010);
  assign sel_ok = (code[14:13] == 2'b00);
  assign all_ok = bl_ok && cas_ok && op_ok && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= MODE_RESET;
      err <= 1'b0;
    end else begin
      err <= load && !all_ok;
      if (load && all_ok) begin
        cur.blen <= bl_dec;
        cur.ilv  <= code[3];
        cur.cas  <= code[6:4];
      end
    end
  end

endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] last_idx,
  output logic             active,
  output logic [OFS_W-1:0] beat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (beat == last_idx) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  input  logic [OFS_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [OFS_W-1:0] ofs_lin, ofs_xor, ofs_sel, ofs_out;

  assign ofs_lin = base[OFS_W-1:0] + beat;
  assign ofs_xor = base[OFS_W-1:0] ^ beat;
  assign ofs_sel = ilv ? ofs_xor : ofs_lin;
  // Bits outside the block mask come from the start column.
  assign ofs_out = (ofs_sel & mask) | (base[OFS_W-1:0] & ~mask);

  generate
    if (COL_W > OFS_W) begin : g_wide
      assign addr = {base[COL_W-1:OFS_W], ofs_out};
    end else begin : g_narrow
      assign addr = ofs_out[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [14:0]       mode_code,
  output logic              mode_err,
  output logic [2:0]        cas_code,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              busy
);

  mode_t            mode_cur;
  mode_t            run_mode;
  logic [COL_W-1:0] base_q;
  logic             active;
  logic [OFS_W-1:0] beat;
  logic [OFS_W-1:0] run_mask;
  logic [COL_W-1:0] gen_addr;
  logic             accept;

  bseq_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .code  (mode_code),
    .cur   (mode_cur),
    .err   (mode_err)
  );

  assign cmd_ready = !active;
  assign accept    = cmd_valid && cmd_ready;

  // Capture the start column and the mode in force at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      run_mode <= MODE_RESET;
    end else if (accept) begin
      base_q   <= cmd_col;
      run_mode <= mode_cur;
    end
  end

  assign run_mask = blen_mask(run_mode.blen);

  bseq_beat_ctrl u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .last_idx (run_mask),
    .active   (active),
    .beat     (beat)
  );

  bseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (base_q),
    .beat (beat),
    .mask (run_mask),
    .ilv  (run_mode.ilv),
    .addr (gen_addr)
  );

  assign col_valid = active;
  assign busy      = active;
  assign col_addr  = active ? gen_addr : '0;
  assign cas_code  = mode_cur.cas;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic             mode_err,
  input logic [2:0]       cas_code,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [COL_W-1:0] cmd_col,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr
);

  logic [3:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (col_valid) run_cnt <= run_cnt + 4'd1;
    else                run_cnt <= '0;
  end

  // R8: first beat is the accepted start column
  p_first_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (col_valid && col_addr == $past(cmd_col)));

  // R8: every run is 2, 4 or 8 beats long
  p_run_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && $past(col_valid)) |->
      ($past(run_cnt) == 4'd1 || $past(run_cnt) == 4'd3 || $past(run_cnt) == 4'd7));

  p_run_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (run_cnt < 4'd8));

  // R11: bits above the widest block never move inside a run
  p_upper_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid)) |-> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));

  // R5: a refused load leaves the CAS field in place
  p_err_keeps_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $stable(cas_code));

  p_err_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(mode_load));

  // R3: stored CAS field is always a legal code
  p_cas_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_code == 3'b010 || cas_code == 3'b110));

  // R7: no acceptance while a burst is streaming
  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid)) |-> $past(!cmd_ready));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_load (mode_load),
  .mode_err  (mode_err),
  .cas_code  (cas_code),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_col   (cmd_col),
  .col_valid (col_valid),
  .col_addr  (col_addr)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [14:0]      mode_code = '0;
  logic             mode_err;
  logic [2:0]       cas_code;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [COL_W-1:0] cmd_col = '0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             busy;

  int n_chk = 0;
  int n_bad = 0;

  int m_len = 2;
  bit m_ilv = 1'b0;
  logic [2:0] m_cas = 3'b010;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_code(mode_code),
    .mode_err(mode_err), .cas_code(cas_code), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_col(cmd_col), .col_valid(col_valid),
    .col_addr(col_addr), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [14:0] c);
    bit ok;
    ok = (c[2:0] == 3'b001) || (c[2:0] == 3'b010) || (c[2:0] == 3'b011);
    ok = ok && (c[6:4] == 3'b010 || c[6:4] == 3'b110);
    ok = ok && (c[12:7] == 6'b000000 || c[12:7] == 6'b000010);
    ok = ok && (c[14:13] == 2'b00);
    return ok;
  endfunction

  function automatic int len_of(input logic [2:0] f);
    return (f == 3'b001) ? 2 : (f == 3'b010) ? 4 : 8;
  endfunction

  function automatic int exp_addr(input int s, input int i, input int len, input bit ilv);
    int lo;
    lo = ilv ? ((s ^ i) & (len - 1)) : ((s + i) % len);
    return (s & ~(len - 1)) | lo;
  endfunction

  function automatic logic [14:0] mk_code(input int blf, input bit ilv, input bit cas25, input bit dll);
    logic [14:0] c;
    c = '0;
    c[2:0]  = blf[2:0];
    c[3]    = ilv;
    c[6:4]  = cas25 ? 3'b110 : 3'b010;
    c[12:7] = dll ? 6'b000010 : 6'b000000;
    return c;
  endfunction

  task automatic apply_model(input logic [14:0] c);
    if (is_legal(c)) begin
      m_len = len_of(c[2:0]);
      m_ilv = c[3];
      m_cas = c[6:4];
    end
  endtask

  // R5 / R1 / R3 / R4: load a code and check error pulse and stored CAS
  task automatic do_load(input logic [14:0] c, input string req);
    bit lg;
    lg = is_legal(c);
    mode_load = 1'b1;
    mode_code = c;
    @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
    check(mode_err == !lg, {req, " R5 err pulse"}, int'(mode_err), int'(!lg));
    apply_model(c);
    check(cas_code == m_cas, {req, " R3 cas_code"}, int'(cas_code), int'(m_cas));
    @(negedge clk);
    check(mode_err == 1'b0, "R5 err one cycle", int'(mode_err), 0);
  endtask

  // kind: 0 plain, 1 offers during burst (R7), 2 load during burst (R12),
  // 3 load in the same cycle as the command (R12)
  task automatic do_burst(input int start, input int kind, input logic [14:0] c);
    int len;
    bit ilv;
    len = m_len;
    ilv = m_ilv;
    check(cmd_ready == 1'b1, "R7 ready when idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_col   = start[COL_W-1:0];
    if (kind == 3) begin
      mode_load = 1'b1;
      mode_code = c;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (kind == 3) begin
      mode_load = 1'b0;
      check(mode_err == !is_legal(c), "R12 same-cycle load err", int'(mode_err), int'(!is_legal(c)));
    end
    for (int i = 0; i < len; i++) begin
      int e;
      e = exp_addr(start, i, len, ilv);
      check(col_valid == 1'b1, "R8 valid during burst", int'(col_valid), 1);
      check(busy == 1'b1 && cmd_ready == 1'b0, "R7 busy/ready in burst", int'({busy, cmd_ready}), 2);
      check(int'(col_addr) == e, ilv ? "R10 R11 interleaved beat" : "R9 R11 linear beat",
            int'(col_addr), e);
      if (kind == 2 && i == 1) begin
        mode_load = 1'b0;
        check(mode_err == !is_legal(c), "R12 mid-burst load err", int'(mode_err), int'(!is_legal(c)));
      end
      if (kind == 2 && i == 0) begin
        mode_load = 1'b1;
        mode_code = c;
      end
      if (kind == 1) begin
        cmd_valid = (i != len - 1);
        cmd_col   = ~start[COL_W-1:0];
      end
      @(negedge clk);
    end
    mode_load = 1'b0;
    cmd_valid = 1'b0;
    check(col_valid == 1'b0 && busy == 1'b0, "R8 R7 burst ends after L beats",
          int'({col_valid, busy}), 0);
    if (kind == 2 || kind == 3) apply_model(c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(col_valid == 0 && busy == 0 && mode_err == 0, "R6 idle outputs",
          int'({col_valid, busy, mode_err}), 0);
    check(cmd_ready == 1'b1, "R6 ready", int'(cmd_ready), 1);
    check(cas_code == 3'b010, "R6 cas", int'(cas_code), 2);
    do_burst(10'h3FF, 0, '0);               // R6 default 2-beat linear wrap

    // R1 R2 directed wrap corners
    do_load(mk_code(3, 1'b0, 1'b0, 1'b0), "R1 len8 lin");
    do_burst(10'h3FF, 0, '0);
    do_burst(10'h155, 0, '0);
    do_load(mk_code(3, 1'b1, 1'b1, 1'b1), "R2 len8 ilv");
    do_burst(10'h0D5, 0, '0);
    do_load(mk_code(2, 1'b1, 1'b0, 1'b0), "R2 len4 ilv");
    do_burst(10'h2A7, 0, '0);
    do_load(mk_code(2, 1'b0, 1'b0, 1'b0), "R1 len4 lin");
    do_burst(10'h003, 0, '0);

    // R1 R3 R4 reserved codes: each must leave the mode alone
    do_load(15'h0000 | 15'h0020 | 15'h0004, "R1 bl 100");
    do_load(15'h0000 | 15'h0020 | 15'h0000, "R1 bl 000");
    do_load(mk_code(3, 1'b0, 1'b0, 1'b0) ^ 15'h0060, "R3 cas 100");
    do_load(mk_code(3, 1'b0, 1'b0, 1'b0) | 15'h2000, "R4 sel bit13");
    do_load(mk_code(3, 1'b0, 1'b0, 1'b0) | 15'h0080, "R4 op 000001");
    do_burst(10'h1FE, 0, '0);               // still 4-beat linear (R5)

    // R7 offers during burst, R12 loads alongside and during bursts
    do_burst(10'h11B, 1, '0);
    do_burst(10'h06E, 3, mk_code(3, 1'b1, 1'b0, 1'b0));
    do_burst(10'h06E, 2, mk_code(1, 1'b0, 1'b1, 1'b0));
    do_burst(10'h271, 0, '0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [14:0] c;
      r = int'($urandom_range(0, 9));
      if (r < 7)
        c = mk_code(int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else
        c = 15'($urandom);
      if (r == 9) c[14:13] = 2'($urandom_range(1, 3));
      do_load(c, "R1 R4 random load");
      for (int b = 0; b < 3; b++) begin
        int k;
        logic [14:0] c2;
        k  = int'($urandom_range(0, 3));
        c2 = (k >= 2) ? mk_code(int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)),
                                1'($urandom_range(0, 1)), 1'b0) : '0;
        do_burst(int'($urandom_range(0, 1023)), k, c2);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule